// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block turns 32 general-purpose input lines into four summary interrupt requests for a main interrupt controller. Every line is brought into the clock domain by a two-flop synchroniser and then passed through a per-bit polarity inverter. The result is the data-in value. Software can read data-in at any time.

Each pin has two interrupt sources. The level source is the data-in bit itself and has no latch. The edge source is a sticky cause bit that is set by a 0-to-1 transition of data-in. Each source has its own mask. The masked sources are ORed per pin, gated by the pin's direction bit, and then ORed in groups of eight to form the four outputs.

Polarity picks the edge: polarity 0 catches a rising line and polarity 1 catches a falling line. A polarity write changes data-in at once, so software can toggle polarity after each event to catch both edges. The register port is a single-cycle write strobe with a combinational read. The registers are:

- 0: direction (1 = input)
- 1: polarity
- 2: data-in (read only)
- 3: level mask
- 4: edge mask
- 5: edge cause

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset the direction register reads all ones, while polarity, level mask, edge mask and edge cause read zero, and all four group outputs are low.
- R2: The data-in register (address 2) reads the synchronised pin value XOR polarity. A pin change appears there after exactly two rising clock edges.
- R3: The level contribution of a pin is its data-in bit AND its level-mask bit (address 3). It is not latched and drops as soon as data-in drops.
- R4: A 0-to-1 transition of a data-in bit sets its edge-cause bit (address 5). The bit stays set after the line returns, and its contribution is gated by the edge-mask bit (address 4).
- R5: Group output g is the OR of the combined causes of pins 8g to 8g+7. The combined cause of a pin is (data-in AND level mask) OR (edge cause AND edge mask).
- R6: A write to address 5 clears every edge-cause bit written 0 and leaves every bit written 1 unchanged.
- R7: When a data-in rise and a clearing write hit the same edge-cause bit in the same cycle, the bit ends up set.
- R8: With polarity 1 a falling pin sets the edge cause. A polarity write (address 1) changes data-in from the next cycle, and the resulting 0-to-1 transition counts as an edge.
- R9: A pin whose direction bit (address 0) is 0 contributes nothing to any group output.
- R10: Writes to address 2 have no effect, and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_pin_i | input | 32 | Raw asynchronous input lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_grp_o | output | 4 | Summary interrupt per group of eight pins |

## Verification
A behavioural model in the bench compares the group outputs and the read data on every cycle. It is driven through several input patterns:

- A single pin pulsed under the level mask only shows that level causes follow the line and edge causes stay latched.
- The same pulse under the edge mask only shows the opposite behaviour.
- A polarity write timed one cycle before a clearing write separates set-wins from clear-wins.
- A falling line under polarity 1 separates falling-edge detection from rising-edge detection.
- Clearing the direction bit of an active pin shows that the direction gate takes priority over the masks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DIR    = 3'd0,
        ADDR_POL    = 3'd1,
        ADDR_DIN    = 3'd2,
        ADDR_LMASK  = 3'd3,
        ADDR_EMASK  = 3'd4,
        ADDR_ECAUSE = 3'd5,
        ADDR_RSV6   = 3'd6,
        ADDR_RSV7   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            warm_q <= 2'd0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    assign sync_o = sync_q;

    // R2: two-edge latency from pin to synchronised value
    assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_q == $past(raw_i, 2)));
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    input  logic             clr_en_i,
    input  logic [WIDTH-1:0] keep_i,
    output logic [WIDTH-1:0] cause_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] held;

    assign rise = din_i & ~prev_q;
    assign held = clr_en_i ? (cause_q & keep_i) : cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= din_i;
            cause_q <= held | rise;
        end
    end

    assign cause_o = cause_q;

    // R7: a rising data-in bit is always captured, even under a clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((cause_q & $past(rise)) == $past(rise)));

    // R4: newly set cause bits only come from a data-in rise
    assert_new_bits_from_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise)) == '0));

    // R6: bits written 0 are gone unless a rise occurred
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((cause_q & ~$past(keep_i) & ~$past(rise)) == '0));
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
    parameter int WIDTH      = 32,
    parameter int GROUP_SIZE = 8
) (
    input  logic [WIDTH-1:0]            cause_i,
    output logic [WIDTH/GROUP_SIZE-1:0] grp_o
);
    localparam int NUM_GROUPS = WIDTH / GROUP_SIZE;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_o[g] = |cause_i[g*GROUP_SIZE +: GROUP_SIZE];
    end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_SIZE = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            gpio_pin_i,
    input  logic                           reg_wr_i,
    input  logic [ADDR_W-1:0]              reg_addr_i,
    input  logic [NUM_PINS-1:0]            reg_wdata_i,
    output logic [NUM_PINS-1:0]            reg_rdata_o,
    output logic [NUM_PINS/GROUP_SIZE-1:0] irq_grp_o
);
    localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

    logic [NUM_PINS-1:0] dir_q, pol_q, lmask_q, emask_q;
    logic [NUM_PINS-1:0] sync_pins, data_in, ecause, combined;
    reg_addr_e           addr;

    assign addr = reg_addr_e'(reg_addr_i);

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (gpio_pin_i),
        .sync_o (sync_pins)
    );

    assign data_in = sync_pins ^ pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            pol_q   <= '0;
            lmask_q <= '0;
            emask_q <= '0;
        end else if (reg_wr_i) begin
            unique case (addr)
                ADDR_DIR:   dir_q   <= reg_wdata_i;
                ADDR_POL:   pol_q   <= reg_wdata_i;
                ADDR_LMASK: lmask_q <= reg_wdata_i;
                ADDR_EMASK: emask_q <= reg_wdata_i;
                default:    ;
            endcase
        end
    end

    gpio_edge_cause #(.WIDTH(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din_i    (data_in),
        .clr_en_i (reg_wr_i && (addr == ADDR_ECAUSE)),
        .keep_i   (reg_wdata_i),
        .cause_o  (ecause)
    );

    assign combined = ((data_in & lmask_q) | (ecause & emask_q)) & dir_q;

    gpio_group_or #(.WIDTH(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_grp (
        .cause_i (combined),
        .grp_o   (irq_grp_o)
    );

    always_comb begin
        unique case (addr)
            ADDR_DIR:    reg_rdata_o = dir_q;
            ADDR_POL:    reg_rdata_o = pol_q;
            ADDR_DIN:    reg_rdata_o = data_in;
            ADDR_LMASK:  reg_rdata_o = lmask_q;
            ADDR_EMASK:  reg_rdata_o = emask_q;
            ADDR_ECAUSE: reg_rdata_o = ecause;
            default:     reg_rdata_o = '0;
        endcase
    end

    // R9: an all-output direction register silences every group
    assert_dir_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == '0) |-> (irq_grp_o == '0));

    // R5: with both masks clear no group can be active
    assert_masks_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lmask_q == '0) && (emask_q == '0)) |-> (irq_grp_o == '0));

    // R8: a polarity write lands on the next cycle
    assert_pol_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (addr == ADDR_POL)) |=> (pol_q == $past(reg_wdata_i)));

    // R10: the number of groups matches the output width
    initial assert_group_count_R10: assert (NUM_GROUPS * GROUP_SIZE == NUM_PINS);
endmodule

// File: tb/gpio_irq_agg_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  grp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_agg dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gpio_pin_i  (pins),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_grp_o   (grp)
    );

    // behavioural reference model
    bit [31:0] m_s1, m_s2, m_prev, m_cause, m_dir, m_pol, m_lm, m_em;

    function automatic bit [31:0] m_din();
        return m_s2 ^ m_pol;
    endfunction

    function automatic bit [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_pol;
            3'd2: return m_din();
            3'd3: return m_lm;
            3'd4: return m_em;
            3'd5: return m_cause;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit [3:0] m_grp();
        bit [3:0] r = '0;
        bit [31:0] d = m_din();
        for (int p = 0; p < 32; p++) begin
            if (m_dir[p] && ((d[p] && m_lm[p]) || (m_cause[p] && m_em[p])))
                r[p/8] = 1'b1;
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_cause = '0;
            m_dir = '1; m_pol = '0; m_lm = '0; m_em = '0;
        end else begin
            bit [31:0] d;
            bit [31:0] nc;
            d  = m_din();
            nc = m_cause;
            for (int p = 0; p < 32; p++) begin
                if (wr && addr == 3'd5 && !wdata[p]) nc[p] = 1'b0;
                if (d[p] && !m_prev[p]) nc[p] = 1'b1;
            end
            m_prev  = d;
            m_cause = nc;
            if (wr) begin
                case (addr)
                    3'd0: m_dir = wdata;
                    3'd1: m_pol = wdata;
                    3'd3: m_lm  = wdata;
                    3'd4: m_em  = wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pins;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R5 outputs, R2 read path)
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R5 per-cycle groups", {28'h0, grp}, {28'h0, m_grp()});
            chk("R2 per-cycle read", rdata, m_read(addr));
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic grp_chk(input string tag, input logic [3:0] exp);
        #1;
        chk(tag, {28'h0, grp}, {28'h0, exp});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 dir reset", 3'd0, 32'hFFFF_FFFF);
        rd_chk("R1 pol reset", 3'd1, 32'h0);
        rd_chk("R1 lmask reset", 3'd3, 32'h0);
        rd_chk("R1 emask reset", 3'd4, 32'h0);
        rd_chk("R1 cause reset", 3'd5, 32'h0);
        grp_chk("R1 groups reset", 4'h0);

        // R2 sync latency on data-in
        addr = 3'd2;
        pins = 32'h0000_0001;
        @(negedge clk); #1;
        chk("R2 one edge: not yet", rdata, 32'h0);
        @(negedge clk); #1;
        chk("R2 two edges: visible", rdata, 32'h1);
        @(negedge clk);

        // R3 level follows line
        wr_reg(3'd3, 32'h0000_00FF);
        grp_chk("R3 level asserted", 4'b0001);
        pins = 32'h0;
        idle(3);
        grp_chk("R3 level drops", 4'b0000);

        // R4 edge latches
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd4, 32'h0000_FF00);
        pins = 32'h0000_0100;
        idle(3);
        pins = 32'h0;
        idle(3);
        grp_chk("R4 edge stays after line drops", 4'b0010);
        rd_chk("R4 cause bits", 3'd5, 32'h0000_0101);

        // R6 clear by writing zero
        wr_reg(3'd5, 32'hFFFF_FEFF);
        rd_chk("R6 cleared only written zero", 3'd5, 32'h0000_0001);
        grp_chk("R6 group off after clear", 4'b0000);

        // R7 set wins against a simultaneous clear
        wr_reg(3'd4, 32'h00FF_0000);
        wr_reg(3'd1, 32'h0001_0000);
        pins = 32'h0001_0000;
        idle(4);
        wr_reg(3'd5, 32'h0);
        rd_chk("R7 cause empty before", 3'd5, 32'h0);
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd5, 32'h0);
        rd_chk("R7 set wins", 3'd5, 32'h0001_0000);
        grp_chk("R7 group raised", 4'b0100);

        // R8 falling edge with polarity 1
        wr_reg(3'd1, 32'h0100_0000);
        pins = 32'h0101_0000;
        idle(4);
        wr_reg(3'd5, 32'h0);
        wr_reg(3'd4, 32'hFF00_0000);
        rd_chk("R8 no edge on high line", 3'd5, 32'h0);
        pins = 32'h0001_0000;
        idle(3);
        rd_chk("R8 falling edge captured", 3'd5, 32'h0100_0000);
        grp_chk("R8 group raised", 4'b1000);

        // R9 direction gate
        wr_reg(3'd5, 32'h0);
        wr_reg(3'd3, 32'h0000_0001);
        pins = 32'h0001_0001;
        idle(3);
        grp_chk("R9 input pin active", 4'b0001);
        wr_reg(3'd0, 32'hFFFF_FFFE);
        grp_chk("R9 output pin silent", 4'b0000);

        // R10 read-only data-in and reserved addresses
        wr_reg(3'd2, 32'hDEAD_BEEF);
        rd_chk("R10 data-in unchanged", 3'd2, 32'h0101_0001);
        rd_chk("R10 reserved 6", 3'd6, 32'h0);
        rd_chk("R10 reserved 7", 3'd7, 32'h0);

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule